// File: doc/BRIEF.md
# SPI Panel Register-Init Sequencer

This block brings up a small LCD panel controller over a write-only SPI link. Once reset is released it walks a fixed table of 24 register/value pairs, built into the design, and writes them in order. Every register write takes two transfers. The first transfer carries the register address. The second carries the 16-bit data word. Each transfer is a 24-bit frame sent under its own chip-select window.

When the last data frame has gone out, the block pulses a completion flag and drops busy. From then on, the panel-enable pin follows on and off requests from the host. An error input is sampled at the end of every frame. If it is high at that point, the walk stops at once and a sticky error flag is raised.

Top module: `panel_init_seq`

## Requirements
- R1: Each chip-select window (cs_n_o low) carries exactly 24 bits, most significant bit first, in SPI mode 0: sclk_o is low while idle, mosi_o changes only while sclk_o is low, and the receiver samples mosi_o on each rising edge of sclk_o.
- R2: An address frame is the byte 0x70, then 0x00, then the table address with bit 7 cleared.
- R3: A data frame is the byte 0x72, then the upper byte of the 16-bit value, then the lower byte.
- R4: For every table entry, the address frame is sent before the data frame. cs_n_o goes high between the two frames and between consecutive entries. It stays high for at least one sclk half-period, which is CLK_DIV system clocks.
- R5: The 24 entries (address=value, hex) are sent in this order: 01=6300, 02=0200, 03=0177, 04=04C7, 05=FFC0, 06=E806, 0A=4008, 0B=0000, 0D=0030, 0E=2800, 0F=0000, 16=9F80, 17=0A0F, 1E=00C1, 30=0300, 31=0007, 32=0000, 33=0000, 34=0707, 35=0004, 36=0302, 37=0202, 3A=0A0D, 3B=0806. A complete run therefore has 48 frames.
- R6: busy_o is high from reset until the last data frame has finished. In the same cycle that busy_o falls, done_o is high for exactly one clock.
- R7: xfer_err_i is sampled in the cycle a frame completes. If it is high, no further frame is sent, err_o goes high and stays high until reset, busy_o falls, and done_o never pulses.
- R8: panel_en_o resets low. It responds to requests only after a successful completion. An on request drives it high and an off request drives it low; if both are high together, the off request wins. Requests made while busy, or after an abort, are ignored.
- R9: While reset is held, cs_n_o is high, sclk_o is low, done_o, err_o and panel_en_o are low, and busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_err_i | input | 1 | Transfer failure indication, sampled at frame end |
| panel_on_req_i | input | 1 | Host request to enable the panel |
| panel_off_req_i | input | 1 | Host request to disable the panel |
| sclk_o | output | 1 | SPI serial clock |
| mosi_o | output | 1 | SPI serial data out |
| cs_n_o | output | 1 | SPI chip select, active low |
| busy_o | output | 1 | Init sequence in progress |
| done_o | output | 1 | One-cycle pulse on successful completion |
| err_o | output | 1 | Sticky abort flag |
| panel_en_o | output | 1 | Panel enable output |

## Verification
The bench builds the block with CLK_DIV=2. At that setting a full 48-frame run is short enough to decode every frame bit by bit and compare it with the complete table, entry by entry. It also measures every chip-select gap against one half-period.

The short frame time also makes room for an abort sweep. An error is injected during the first frame, the second frame, a middle data frame and the final frame, and each run checks the exact number of frames sent. Around the completion and abort points, enable and disable requests are applied to exercise the gating and the off-wins priority.

// File: rtl/panel_init_pkg.sv
package panel_init_pkg;
    localparam int FRAME_W     = 24;
    localparam int NUM_ENTRIES = 24;
    localparam int ENT_W       = $clog2(NUM_ENTRIES);
    localparam int BIT_W       = $clog2(FRAME_W);

    localparam logic [7:0] ADDR_LEAD = 8'h70;
    localparam logic [7:0] DATA_LEAD = 8'h72;

    typedef struct packed {
        logic [7:0]  addr;
        logic [15:0] data;
    } reg_pair_t;

    // Ordered bring-up table; position in the table is the send order.
    function automatic reg_pair_t init_pair(input logic [ENT_W-1:0] n);
        reg_pair_t p;
        case (n)
            5'd0:  p = '{8'h01, 16'h6300};
            5'd1:  p = '{8'h02, 16'h0200};
            5'd2:  p = '{8'h03, 16'h0177};
            5'd3:  p = '{8'h04, 16'h04C7};
            5'd4:  p = '{8'h05, 16'hFFC0};
            5'd5:  p = '{8'h06, 16'hE806};
            5'd6:  p = '{8'h0A, 16'h4008};
            5'd7:  p = '{8'h0B, 16'h0000};
            5'd8:  p = '{8'h0D, 16'h0030};
            5'd9:  p = '{8'h0E, 16'h2800};
            5'd10: p = '{8'h0F, 16'h0000};
            5'd11: p = '{8'h16, 16'h9F80};
            5'd12: p = '{8'h17, 16'h0A0F};
            5'd13: p = '{8'h1E, 16'h00C1};
            5'd14: p = '{8'h30, 16'h0300};
            5'd15: p = '{8'h31, 16'h0007};
            5'd16: p = '{8'h32, 16'h0000};
            5'd17: p = '{8'h33, 16'h0000};
            5'd18: p = '{8'h34, 16'h0707};
            5'd19: p = '{8'h35, 16'h0004};
            5'd20: p = '{8'h36, 16'h0302};
            5'd21: p = '{8'h37, 16'h0202};
            5'd22: p = '{8'h3A, 16'h0A0D};
            5'd23: p = '{8'h3B, 16'h0806};
            default: p = '0;
        endcase
        return p;
    endfunction
endpackage

// File: rtl/panel_frame_build.sv
module panel_frame_build
    import panel_init_pkg::*;
(
    input  logic [ENT_W-1:0]   entry_i,
    input  logic               data_phase_i,
    output logic [FRAME_W-1:0] frame_o
);
    reg_pair_t pair;

    always_comb begin
        pair = init_pair(entry_i);
        if (data_phase_i)
            frame_o = {DATA_LEAD, pair.data};
        else
            // R2: address byte goes out with bit 7 cleared
            frame_o = {ADDR_LEAD, 8'h00, pair.addr & 8'h7F};
    end
endmodule

// File: rtl/panel_spi_tx.sv
module panel_spi_tx
    import panel_init_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic               fin_o,
    output logic               sclk_o,
    output logic               mosi_o,
    output logic               cs_n_o
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

    typedef enum logic [1:0] {TX_IDLE, TX_SHIFT, TX_GAP} tx_st_e;

    typedef struct packed {
        tx_st_e             st;
        logic [DIV_W-1:0]   cnt;
        logic [BIT_W-1:0]   bitn;
        logic [FRAME_W-1:0] sh;
        logic               sclk;
        logic               cs_n;
        logic               fin;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d     = tx_q;
        tx_d.fin = 1'b0;
        unique case (tx_q.st)
            TX_IDLE: begin
                if (start_i) begin
                    tx_d.sh   = frame_i;
                    tx_d.cs_n = 1'b0;
                    tx_d.sclk = 1'b0;
                    tx_d.cnt  = '0;
                    tx_d.bitn = '0;
                    tx_d.st   = TX_SHIFT;
                end
            end
            TX_SHIFT: begin
                if (tx_q.cnt == DIV_LAST) begin
                    tx_d.cnt = '0;
                    if (!tx_q.sclk) begin
                        tx_d.sclk = 1'b1;
                    end else begin
                        tx_d.sclk = 1'b0;
                        if (tx_q.bitn == BIT_LAST) begin
                            tx_d.cs_n = 1'b1;
                            tx_d.st   = TX_GAP;
                        end else begin
                            tx_d.bitn = tx_q.bitn + 1'b1;
                            tx_d.sh   = {tx_q.sh[FRAME_W-2:0], 1'b0};
                        end
                    end
                end else begin
                    tx_d.cnt = tx_q.cnt + 1'b1;
                end
            end
            TX_GAP: begin
                if (tx_q.cnt == DIV_LAST) begin
                    tx_d.cnt = '0;
                    tx_d.fin = 1'b1;
                    tx_d.st  = TX_IDLE;
                end else begin
                    tx_d.cnt = tx_q.cnt + 1'b1;
                end
            end
            default: tx_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q      <= '0;
            tx_q.st   <= TX_IDLE;
            tx_q.cs_n <= 1'b1;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign fin_o  = tx_q.fin;
    assign sclk_o = tx_q.sclk;
    assign cs_n_o = tx_q.cs_n;
    assign mosi_o = tx_q.cs_n ? 1'b0 : tx_q.sh[FRAME_W-1];
endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
    import panel_init_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_err_i,
    input  logic panel_on_req_i,
    input  logic panel_off_req_i,
    output logic sclk_o,
    output logic mosi_o,
    output logic cs_n_o,
    output logic busy_o,
    output logic done_o,
    output logic err_o,
    output logic panel_en_o
);
    localparam logic [ENT_W-1:0] ENT_LAST = ENT_W'(NUM_ENTRIES - 1);

    typedef enum logic [2:0] {SQ_LOAD, SQ_WAIT, SQ_DONE, SQ_ABORT} sq_st_e;

    typedef struct packed {
        sq_st_e           st;
        logic [ENT_W-1:0] entry;
        logic             data_phase;
        logic             busy;
        logic             done;
        logic             err;
        logic             pen;
    } sq_t;

    sq_t sq_d, sq_q;

    logic               tx_start;
    logic               tx_fin;
    logic [FRAME_W-1:0] frame;

    panel_frame_build u_build (
        .entry_i      (sq_q.entry),
        .data_phase_i (sq_q.data_phase),
        .frame_o      (frame)
    );

    panel_spi_tx #(.CLK_DIV(CLK_DIV)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tx_start),
        .frame_i (frame),
        .fin_o   (tx_fin),
        .sclk_o  (sclk_o),
        .mosi_o  (mosi_o),
        .cs_n_o  (cs_n_o)
    );

    assign tx_start = (sq_q.st == SQ_LOAD);

    always_comb begin
        sq_d      = sq_q;
        sq_d.done = 1'b0;
        unique case (sq_q.st)
            SQ_LOAD: sq_d.st = SQ_WAIT;
            SQ_WAIT: begin
                if (tx_fin) begin
                    if (xfer_err_i) begin
                        sq_d.err  = 1'b1;
                        sq_d.busy = 1'b0;
                        sq_d.st   = SQ_ABORT;
                    end else if (!sq_q.data_phase) begin
                        sq_d.data_phase = 1'b1;
                        sq_d.st         = SQ_LOAD;
                    end else if (sq_q.entry == ENT_LAST) begin
                        sq_d.busy = 1'b0;
                        sq_d.done = 1'b1;
                        sq_d.st   = SQ_DONE;
                    end else begin
                        sq_d.entry      = sq_q.entry + 1'b1;
                        sq_d.data_phase = 1'b0;
                        sq_d.st         = SQ_LOAD;
                    end
                end
            end
            SQ_DONE: begin
                if (panel_off_req_i)
                    sq_d.pen = 1'b0;
                else if (panel_on_req_i)
                    sq_d.pen = 1'b1;
            end
            SQ_ABORT: sq_d.st = SQ_ABORT;
            default:  sq_d.st = SQ_ABORT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q      <= '0;
            sq_q.st   <= SQ_LOAD;
            sq_q.busy <= 1'b1;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign busy_o     = sq_q.busy;
    assign done_o     = sq_q.done;
    assign err_o      = sq_q.err;
    assign panel_en_o = sq_q.pen;
endmodule

// File: rtl/panel_init_chk.sv
module panel_init_chk (
    input logic clk,
    input logic rst_n,
    input logic sclk_o,
    input logic mosi_o,
    input logic cs_n_o,
    input logic busy_o,
    input logic done_o,
    input logic err_o,
    input logic panel_en_o
);
    // R1
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    // R1
    sclk_rise_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> !cs_n_o);

    // R1
    mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && !cs_n_o && $past(sclk_o)) |-> $stable(mosi_o));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R6
    busy_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> !busy_o);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // R7
    err_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!done_o && !busy_o && cs_n_o));

    // R8
    pen_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o || err_o) |-> !panel_en_o);
endmodule

bind panel_init_seq panel_init_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_o     (sclk_o),
    .mosi_o     (mosi_o),
    .cs_n_o     (cs_n_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .panel_en_o (panel_en_o)
);

// File: tb/tb_panel_init_seq.sv
module tb_panel_init_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam int NENT       = 24;
    localparam int NFR        = 2 * NENT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer_err = 1'b0;
    logic on_req = 1'b0;
    logic off_req = 1'b0;
    logic sclk, mosi, cs_n, busy, done, err, pen;

    panel_init_seq #(.CLK_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .xfer_err_i(xfer_err),
        .panel_on_req_i(on_req), .panel_off_req_i(off_req),
        .sclk_o(sclk), .mosi_o(mosi), .cs_n_o(cs_n),
        .busy_o(busy), .done_o(done), .err_o(err), .panel_en_o(pen)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;

    logic [7:0]  tab_a [0:NENT-1];
    logic [15:0] tab_v [0:NENT-1];
    logic [23:0] exp_f [0:NFR-1];
    logic [23:0] got_f [0:63];
    int          got_n [0:63];

    int nfr, bitc, gap, min_gap, done_cnt, done_run, done_wide, busy_fall_ok;
    logic [23:0] shr;
    logic prev_sclk, prev_cs, prev_busy;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Frame monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            nfr = 0; bitc = 0; gap = 0; min_gap = 1000; shr = '0;
            done_cnt = 0; done_run = 0; done_wide = 0; busy_fall_ok = 1;
            prev_sclk = 1'b0; prev_cs = 1'b1; prev_busy = 1'b1;
        end else begin
            if (!cs_n && sclk && !prev_sclk) begin
                shr = {shr[22:0], mosi};
                bitc++;
            end
            if (cs_n && !prev_cs) begin
                if (nfr < 64) begin
                    got_f[nfr] = shr;
                    got_n[nfr] = bitc;
                end
                nfr++;
                bitc = 0;
                gap = 0;
            end
            if (cs_n && prev_cs) gap++;
            if (!cs_n && prev_cs && nfr > 0 && gap + 1 < min_gap) min_gap = gap + 1;
            if (done) begin
                done_cnt++;
                done_run++;
                if (done_run > 1) done_wide = 1;
            end else begin
                done_run = 0;
            end
            if (!busy && prev_busy && !done && !err) busy_fall_ok = 0;
            prev_sclk = sclk;
            prev_cs = cs_n;
            prev_busy = busy;
        end
    end

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(cs_n == 1'b1, "R9 cs_n in reset", cs_n, 1);
        chk(sclk == 1'b0, "R9 sclk in reset", sclk, 0);
        chk({done, err, pen} == 3'b000, "R9 done/err/pen in reset", {done, err, pen}, 0);
        chk(busy == 1'b1, "R9 busy in reset", busy, 1);
        rst_n = 1'b1;
    endtask

    task automatic wait_end;
        int t = 0;
        while (done_cnt == 0 && !err && t < 40000) begin
            @(negedge clk);
            t++;
        end
        repeat (50) @(negedge clk);
    endtask

    task automatic pulse(input bit on, input bit off);
        on_req = on; off_req = off;
        @(negedge clk);
        on_req = 1'b0; off_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin
        tab_a[0]=8'h01;  tab_v[0]=16'h6300;  tab_a[1]=8'h02;  tab_v[1]=16'h0200;
        tab_a[2]=8'h03;  tab_v[2]=16'h0177;  tab_a[3]=8'h04;  tab_v[3]=16'h04C7;
        tab_a[4]=8'h05;  tab_v[4]=16'hFFC0;  tab_a[5]=8'h06;  tab_v[5]=16'hE806;
        tab_a[6]=8'h0A;  tab_v[6]=16'h4008;  tab_a[7]=8'h0B;  tab_v[7]=16'h0000;
        tab_a[8]=8'h0D;  tab_v[8]=16'h0030;  tab_a[9]=8'h0E;  tab_v[9]=16'h2800;
        tab_a[10]=8'h0F; tab_v[10]=16'h0000; tab_a[11]=8'h16; tab_v[11]=16'h9F80;
        tab_a[12]=8'h17; tab_v[12]=16'h0A0F; tab_a[13]=8'h1E; tab_v[13]=16'h00C1;
        tab_a[14]=8'h30; tab_v[14]=16'h0300; tab_a[15]=8'h31; tab_v[15]=16'h0007;
        tab_a[16]=8'h32; tab_v[16]=16'h0000; tab_a[17]=8'h33; tab_v[17]=16'h0000;
        tab_a[18]=8'h34; tab_v[18]=16'h0707; tab_a[19]=8'h35; tab_v[19]=16'h0004;
        tab_a[20]=8'h36; tab_v[20]=16'h0302; tab_a[21]=8'h37; tab_v[21]=16'h0202;
        tab_a[22]=8'h3A; tab_v[22]=16'h0A0D; tab_a[23]=8'h3B; tab_v[23]=16'h0806;
        for (int i = 0; i < NENT; i++) begin
            exp_f[2*i]   = {8'h70, 8'h00, 1'b0, tab_a[i][6:0]};
            exp_f[2*i+1] = {8'h72, tab_v[i]};
        end

        // ---------- full successful run ----------
        do_reset();
        repeat (200) @(negedge clk);
        pulse(1'b1, 1'b0);
        // R8: request while busy is ignored
        chk(pen == 1'b0 && busy == 1'b1, "R8 enable ignored while busy", pen, 0);
        wait_end();
        chk(nfr == NFR, "R5 frame count", nfr, NFR);
        for (int f = 0; f < NFR; f++) begin
            // R1: 24 bits per window, MSB first
            chk(got_n[f] == 24, "R1 bits per frame", got_n[f], 24);
            // R2 (even frames) / R3 (odd frames) / R5 order
            chk(got_f[f] == exp_f[f], (f % 2 == 0) ? "R2 R5 address frame" : "R3 R5 data frame",
                got_f[f], exp_f[f]);
        end
        chk(min_gap >= DIV, "R4 chip-select gap", min_gap, DIV);
        chk(done_cnt == 1 && done_wide == 0, "R6 single done pulse", done_cnt, 1);
        chk(busy == 1'b0 && busy_fall_ok == 1, "R6 busy falls with done", busy, 0);
        chk(err == 1'b0, "R7 no error on clean run", err, 0);
        // R8: gating after completion
        chk(pen == 1'b0, "R8 enable low after done", pen, 0);
        pulse(1'b1, 1'b0);
        chk(pen == 1'b1, "R8 on request", pen, 1);
        pulse(1'b0, 1'b0);
        chk(pen == 1'b1, "R8 holds without request", pen, 1);
        pulse(1'b1, 1'b1);
        chk(pen == 1'b0, "R8 off wins over on", pen, 0);
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b1);
        chk(pen == 1'b0, "R8 off request", pen, 0);

        // ---------- abort sweep ----------
        foreach (exp_f[k]) begin
            if (k == 0 || k == 1 || k == 17 || k == NFR - 1) begin
                do_reset();
                while (!(nfr == k && !cs_n)) @(negedge clk);
                xfer_err = 1'b1;
                wait_end();
                xfer_err = 1'b0;
                repeat (100) @(negedge clk);
                chk(nfr == k + 1, "R7 frames sent before abort", nfr, k + 1);
                chk(err == 1'b1 && busy == 1'b0, "R7 error flagged, not busy", {err, busy}, 2'b10);
                chk(done_cnt == 0, "R7 no done on abort", done_cnt, 0);
                pulse(1'b1, 1'b0);
                chk(pen == 1'b0, "R8 enable ignored after abort", pen, 0);
            end
        end

        summary();
        $finish;
    end
endmodule